// File: doc/BRIEF.md
# Index Register Address Generator

This block keeps a bank of sixteen pointer registers and a bank of sixteen data registers, and turns each operand request into an effective memory address. A request carries a mode code, a pointer select, a data-register select, a 12-bit signed immediate and a step-size bit. The address and its valid strobe come back combinationally in the same cycle. The two auto-modify modes write the updated pointer back on the next rising clock edge.

A separate load command writes an address directly into one pointer register. A data-register write port fills the offset registers used by the register-offset mode. All address arithmetic is 32 bits wide and wraps modulo 2^32 without reporting overflow.

Top module: `idx_addr_gen`

## Requirements
- R1: An active-high synchronous reset clears all sixteen pointer registers and all sixteen data registers to zero. The pointer used by a request is chosen by the 4-bit `reqIrSel`.
- R2: The mode code is 0 for plain indirect. In this mode `eaValid` is high in the same cycle as `reqValid`, `eaAddr` equals the selected pointer, and the pointer keeps its value.
- R3: With mode code 1, `eaAddr` is the pointer plus `reqOffset` read as 12-bit two's complement (-2048 to 2047), and the pointer keeps its value.
- R4: With mode code 2, `eaAddr` is the pointer plus the data register chosen by `reqDrSel`, sign-extended from 16 bits, and the pointer keeps its value. A data-register write is seen by requests from the cycle after it.
- R5: With mode code 3 (post-increment), `eaAddr` is the unmodified pointer. At the next edge the pointer grows by 1 when `reqStep2` is 0 and by 2 when it is 1.
- R6: With mode code 4 (pre-decrement), `eaAddr` is the pointer minus 1 (`reqStep2`=0) or minus 2 (`reqStep2`=1). That reduced value is stored back at the next edge.
- R7: A load command writes `ldAddr` into pointer `ldSel` at the next edge. When it targets the same pointer as an auto-modify request in the same cycle, the loaded value is kept. When it targets a different pointer, both writes take effect.
- R8: Address sums and pointer updates wrap modulo 2^32.
- R9: Mode codes 5 to 7, or a low `reqValid`, give a low `eaValid` and change no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Operand request present |
| reqMode | input | 3 | Addressing mode code |
| reqIrSel | input | 4 | Pointer register select |
| reqDrSel | input | 4 | Data register select for mode 2 |
| reqOffset | input | 12 | Signed immediate for mode 1 |
| reqStep2 | input | 1 | Auto-modify step: 0 gives 1, 1 gives 2 |
| ldValid | input | 1 | Pointer load command |
| ldSel | input | 4 | Pointer register to load |
| ldAddr | input | 32 | Address to load |
| drWrValid | input | 1 | Data register write |
| drWrSel | input | 4 | Data register to write |
| drWrData | input | 16 | Data register write value |
| eaValid | output | 1 | Effective address valid |
| eaAddr | output | 32 | Effective address |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, sixteen of each register and a 12-bit immediate. With these values the immediate reaches both of its extremes (2047 and -2048), and a pointer can be taken across zero in both directions, which exercises the 2^32 wrap. A 16-bit data register holding a negative value checks sign extension at full width. Every pointer and data register is read after reset, and a mid-run reset is applied to confirm that stored state is cleared.

// File: rtl/idx_addr_pkg.sv
package idx_addr_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_PLAIN   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CONST   = 3'd1;
  localparam logic [MODE_W-1:0] MODE_DREG    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_POSTINC = 3'd3;
  localparam logic [MODE_W-1:0] MODE_PREDEC  = 3'd4;

  // strobes from the mode decoder to the datapath
  typedef struct packed {
    logic eaEn;      // request is legal, address is valid
    logic addConst;  // add sign-extended immediate
    logic addDreg;   // add sign-extended data register
    logic preDec;    // subtract step before use
    logic wbEn;      // write updated pointer back
    logic stepTwo;   // step is 2 instead of 1
  } ctrl_t;

endpackage

// File: rtl/idx_addr_ctrl.sv
module idx_addr_ctrl
  import idx_addr_pkg::*;
(
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              reqStep2,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.stepTwo = reqStep2;
    if (reqValid) begin
      case (reqMode)
        MODE_PLAIN:   ctrl.eaEn = 1'b1;
        MODE_CONST: begin
          ctrl.eaEn     = 1'b1;
          ctrl.addConst = 1'b1;
        end
        MODE_DREG: begin
          ctrl.eaEn    = 1'b1;
          ctrl.addDreg = 1'b1;
        end
        MODE_POSTINC: begin
          ctrl.eaEn = 1'b1;
          ctrl.wbEn = 1'b1;
        end
        MODE_PREDEC: begin
          ctrl.eaEn   = 1'b1;
          ctrl.preDec = 1'b1;
          ctrl.wbEn   = 1'b1;
        end
        default: ctrl.eaEn = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/idx_addr_dp.sv
module idx_addr_dp
  import idx_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_IR = 16,
  parameter int NUM_DR = 16,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 12,
  localparam int IR_SEL_W = $clog2(NUM_IR),
  localparam int DR_SEL_W = $clog2(NUM_DR)
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrl_t               ctrl,
  input  logic [IR_SEL_W-1:0] reqIrSel,
  input  logic [DR_SEL_W-1:0] reqDrSel,
  input  logic [OFS_W-1:0]    reqOffset,
  input  logic                ldValid,
  input  logic [IR_SEL_W-1:0] ldSel,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic                drWrValid,
  input  logic [DR_SEL_W-1:0] drWrSel,
  input  logic [DATA_W-1:0]   drWrData,
  output logic                eaValid,
  output logic [ADDR_W-1:0]   eaAddr
);

  logic [ADDR_W-1:0] irBank [NUM_IR];
  logic [DATA_W-1:0] drBank [NUM_DR];

  logic [ADDR_W-1:0] baseVal;
  logic [ADDR_W-1:0] constExt;
  logic [ADDR_W-1:0] drExt;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] addend;
  logic [ADDR_W-1:0] wbValue;

  always_comb begin
    baseVal  = irBank[reqIrSel];
    constExt = {{(ADDR_W-OFS_W){reqOffset[OFS_W-1]}}, reqOffset};
    drExt    = {{(ADDR_W-DATA_W){drBank[reqDrSel][DATA_W-1]}}, drBank[reqDrSel]};
    stepVal  = ctrl.stepTwo ? ADDR_W'(2) : ADDR_W'(1);
    if (ctrl.addConst)      addend = constExt;
    else if (ctrl.addDreg)  addend = drExt;
    else if (ctrl.preDec)   addend = '0 - stepVal;
    else                    addend = '0;
    eaAddr  = baseVal + addend;
    wbValue = ctrl.preDec ? eaAddr : baseVal + stepVal;
    eaValid = ctrl.eaEn;
  end

  // pointer bank: load command has priority over auto-modify write-back
  for (genvar g = 0; g < NUM_IR; g++) begin : gIr
    always_ff @(posedge clk) begin
      if (rst)
        irBank[g] <= '0;
      else if (ldValid && ldSel == IR_SEL_W'(g))
        irBank[g] <= ldAddr;
      else if (ctrl.wbEn && reqIrSel == IR_SEL_W'(g))
        irBank[g] <= wbValue;
    end
  end

  for (genvar g = 0; g < NUM_DR; g++) begin : gDr
    always_ff @(posedge clk) begin
      if (rst)
        drBank[g] <= '0;
      else if (drWrValid && drWrSel == DR_SEL_W'(g))
        drBank[g] <= drWrData;
    end
  end

endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_IR = 16,
  parameter int NUM_DR = 16,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 12,
  localparam int IR_SEL_W = $clog2(NUM_IR),
  localparam int DR_SEL_W = $clog2(NUM_DR)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [MODE_W-1:0]   reqMode,
  input  logic [IR_SEL_W-1:0] reqIrSel,
  input  logic [DR_SEL_W-1:0] reqDrSel,
  input  logic [OFS_W-1:0]    reqOffset,
  input  logic                reqStep2,
  input  logic                ldValid,
  input  logic [IR_SEL_W-1:0] ldSel,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic                drWrValid,
  input  logic [DR_SEL_W-1:0] drWrSel,
  input  logic [DATA_W-1:0]   drWrData,
  output logic                eaValid,
  output logic [ADDR_W-1:0]   eaAddr
);

  ctrl_t ctrl;

  idx_addr_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .reqStep2 (reqStep2),
    .ctrl     (ctrl)
  );

  idx_addr_dp #(
    .ADDR_W (ADDR_W),
    .NUM_IR (NUM_IR),
    .NUM_DR (NUM_DR),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .reqIrSel  (reqIrSel),
    .reqDrSel  (reqDrSel),
    .reqOffset (reqOffset),
    .ldValid   (ldValid),
    .ldSel     (ldSel),
    .ldAddr    (ldAddr),
    .drWrValid (drWrValid),
    .drWrSel   (drWrSel),
    .drWrData  (drWrData),
    .eaValid   (eaValid),
    .eaAddr    (eaAddr)
  );

endmodule

// File: rtl/idx_addr_chk.sv
module idx_addr_chk
  import idx_addr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IR_SEL_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                reqValid,
  input logic [MODE_W-1:0]   reqMode,
  input logic [IR_SEL_W-1:0] reqIrSel,
  input logic                reqStep2,
  input logic                ldValid,
  input logic [IR_SEL_W-1:0] ldSel,
  input logic [ADDR_W-1:0]   ldAddr,
  input logic                eaValid,
  input logic [ADDR_W-1:0]   eaAddr
);

  logic plainReq;
  assign plainReq = reqValid && reqMode == MODE_PLAIN;

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    eaValid |-> reqValid);  // R2

  AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode > MODE_PREDEC) |-> !eaValid);  // R9

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
    (plainReq && !$past(rst) && $past(reqValid && reqMode == MODE_POSTINC)
     && !$past(ldValid && ldSel == reqIrSel) && reqIrSel == $past(reqIrSel))
    |-> eaAddr == $past(eaAddr) + ($past(reqStep2) ? ADDR_W'(2) : ADDR_W'(1)));  // R5

  AST_PREDEC_STORE: assert property (@(posedge clk) disable iff (rst)
    (plainReq && !$past(rst) && $past(reqValid && reqMode == MODE_PREDEC)
     && !$past(ldValid && ldSel == reqIrSel) && reqIrSel == $past(reqIrSel))
    |-> eaAddr == $past(eaAddr));  // R6

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (plainReq && !$past(rst) && $past(ldValid) && reqIrSel == $past(ldSel))
    |-> eaAddr == $past(ldAddr));  // R7

endmodule

bind idx_addr_gen idx_addr_chk #(
  .ADDR_W   (ADDR_W),
  .IR_SEL_W (IR_SEL_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqMode  (reqMode),
  .reqIrSel (reqIrSel),
  .reqStep2 (reqStep2),
  .ldValid  (ldValid),
  .ldSel    (ldSel),
  .ldAddr   (ldAddr),
  .eaValid  (eaValid),
  .eaAddr   (eaAddr)
);

// File: tb/sim_idx_addr_gen.sv
module sim_idx_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  typedef struct packed {
    logic        ld;
    logic [3:0]  ldSel;
    logic [31:0] ldAddr;
    logic        rq;
    logic [2:0]  mode;
    logic [3:0]  sel;
    logic [11:0] ofs;
    logic        st2;
    logic        expV;
    logic [31:0] expEa;
    logic [3:0]  tag;
  } vec_t;

  // each row: load part commits at the edge after; request answered in-cycle
  localparam vec_t VEC [0:NVEC-1] = '{
    '{1'b1, 4'd3, 32'h0000_1000, 1'b0, 3'd0, 4'd3, 12'h000, 1'b0, 1'b0, 32'h0,          4'd7}, // R7 load IR3
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd3, 12'h000, 1'b0, 1'b1, 32'h0000_1000, 4'd2}, // R2
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd1, 4'd3, 12'h7FF, 1'b0, 1'b1, 32'h0000_17FF, 4'd3}, // R3 +2047
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd1, 4'd3, 12'h800, 1'b0, 1'b1, 32'h0000_0800, 4'd3}, // R3 -2048
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd3, 12'h000, 1'b0, 1'b1, 32'h0000_1000, 4'd3}, // R3 unchanged
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd3, 4'd3, 12'h000, 1'b0, 1'b1, 32'h0000_1000, 4'd5}, // R5 step 1
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd3, 4'd3, 12'h000, 1'b1, 1'b1, 32'h0000_1001, 4'd5}, // R5 step 2
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd3, 12'h000, 1'b0, 1'b1, 32'h0000_1003, 4'd5}, // R5
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd4, 4'd3, 12'h000, 1'b1, 1'b1, 32'h0000_1001, 4'd6}, // R6 step 2
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd4, 4'd3, 12'h000, 1'b0, 1'b1, 32'h0000_1000, 4'd6}, // R6 step 1
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd3, 12'h000, 1'b0, 1'b1, 32'h0000_1000, 4'd6}, // R6 stored
    '{1'b1, 4'd5, 32'h0000_0020, 1'b1, 3'd4, 4'd5, 12'h000, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'd8}, // R8 wrap down
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd5, 12'h000, 1'b0, 1'b1, 32'h0000_0020, 4'd7}, // R7 load wins
    '{1'b1, 4'd0, 32'hFFFF_FFFF, 1'b1, 3'd3, 4'd5, 12'h000, 1'b1, 1'b1, 32'h0000_0020, 4'd7}, // R7 both
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd0, 12'h000, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'd7}, // R7
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd5, 12'h000, 1'b0, 1'b1, 32'h0000_0022, 4'd7}, // R7
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd3, 4'd0, 12'h000, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'd8}, // R8
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd0, 12'h000, 1'b0, 1'b1, 32'h0000_0000, 4'd8}, // R8 wrap up
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd6, 4'd5, 12'h000, 1'b1, 1'b0, 32'h0,          4'd9}, // R9 reserved
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd5, 12'h000, 1'b0, 1'b1, 32'h0000_0022, 4'd9}, // R9
    '{1'b0, 4'd0, 32'h0,         1'b0, 3'd3, 4'd5, 12'h000, 1'b1, 1'b0, 32'h0,          4'd9}, // R9 idle
    '{1'b0, 4'd0, 32'h0,         1'b1, 3'd0, 4'd5, 12'h000, 1'b0, 1'b1, 32'h0000_0022, 4'd9}  // R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMode = '0;
  logic [3:0]  reqIrSel = '0;
  logic [3:0]  reqDrSel = '0;
  logic [11:0] reqOffset = '0;
  logic        reqStep2 = 1'b0;
  logic        ldValid = 1'b0;
  logic [3:0]  ldSel = '0;
  logic [31:0] ldAddr = '0;
  logic        drWrValid = 1'b0;
  logic [3:0]  drWrSel = '0;
  logic [15:0] drWrData = '0;
  logic        eaValid;
  logic [31:0] eaAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  idx_addr_gen u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqMode(reqMode),
    .reqIrSel(reqIrSel), .reqDrSel(reqDrSel), .reqOffset(reqOffset),
    .reqStep2(reqStep2), .ldValid(ldValid), .ldSel(ldSel), .ldAddr(ldAddr),
    .drWrValid(drWrValid), .drWrSel(drWrSel), .drWrData(drWrData),
    .eaValid(eaValid), .eaAddr(eaAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 1'b0; ldValid = 1'b0; drWrValid = 1'b0;
    reqMode = '0; reqStep2 = 1'b0; reqOffset = '0;
  endtask

  // drive a request after the falling edge, sample it 1 time unit later
  task automatic request(input logic [2:0] m, input logic [3:0] s, input logic [3:0] d,
                         input logic [11:0] o, input logic st);
    @(negedge clk);
    idle();
    reqValid = 1'b1; reqMode = m; reqIrSel = s; reqDrSel = d; reqOffset = o; reqStep2 = st;
    #1;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every pointer and data register reads zero after reset
    for (int i = 0; i < 16; i++) begin
      request(3'd0, 4'(i), 4'd0, 12'h0, 1'b0);
      check("R1 pointer after reset", eaAddr, 32'h0);
    end
    for (int i = 0; i < 16; i++) begin
      request(3'd2, 4'd1, 4'(i), 12'h0, 1'b0);
      check("R1 data reg after reset", eaAddr, 32'h0);
    end

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      idle();
      ldValid = VEC[i].ld; ldSel = VEC[i].ldSel; ldAddr = VEC[i].ldAddr;
      reqValid = VEC[i].rq; reqMode = VEC[i].mode; reqIrSel = VEC[i].sel;
      reqOffset = VEC[i].ofs; reqStep2 = VEC[i].st2;
      #1;
      check($sformatf("R%0d vector %0d valid", VEC[i].tag, i), 32'(eaValid), 32'(VEC[i].expV));
      if (VEC[i].expV)
        check($sformatf("R%0d vector %0d addr", VEC[i].tag, i), eaAddr, VEC[i].expEa);
    end

    // R4: data register offsets; IR3 holds 0x1000
    @(negedge clk);
    idle();
    drWrValid = 1'b1; drWrSel = 4'd2; drWrData = 16'hFFFE;
    request(3'd2, 4'd3, 4'd2, 12'h0, 1'b0);
    check("R4 negative data reg", eaAddr, 32'h0000_0FFE);
    drWrValid = 1'b1; drWrSel = 4'd2; drWrData = 16'h0005;
    #1;
    check("R4 write not seen same cycle", eaAddr, 32'h0000_0FFE);
    request(3'd2, 4'd3, 4'd2, 12'h0, 1'b0);
    check("R4 rewritten data reg", eaAddr, 32'h0000_1005);
    drWrValid = 1'b1; drWrSel = 4'd7; drWrData = 16'h7FFF;
    request(3'd2, 4'd3, 4'd7, 12'h0, 1'b0);
    check("R4 max positive data reg", eaAddr, 32'h0000_8FFF);
    request(3'd0, 4'd3, 4'd0, 12'h0, 1'b0);
    check("R4 pointer unchanged", eaAddr, 32'h0000_1000);

    // R1: mid-run reset clears stored state
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    request(3'd0, 4'd3, 4'd0, 12'h0, 1'b0);
    check("R1 pointer after mid-run reset", eaAddr, 32'h0);
    request(3'd2, 4'd5, 4'd7, 12'h0, 1'b0);
    check("R1 data reg after mid-run reset", eaAddr, 32'h0);

    @(negedge clk);
    idle();
    finish();
  end

endmodule